// File: doc/BRIEF.md
# Cyclic (7,3) Codec with Single-Error Correction

This block holds two independent paths for one short cyclic code. The code has a length of 7 and carries 3 message bits. Its generator is g(x) = 1 + x + x^2 + x^4. Bit i of every 7-bit vector is the coefficient of x^i.

The encode path accepts a 3-bit message under a valid strobe. It returns the systematic codeword one clock later. The message sits in bits 6:4, and the parity sits in bits 3:0. The parity is m(x)·x^4 mod g(x).

The decode path accepts a 7-bit received word under its own valid strobe. It divides the word by g(x) to form a 4-bit syndrome and classifies the result:

- **Zero syndrome:** the word is accepted as is.
- **Syndrome equal to x^i mod g(x):** bit i is inverted and a correction flag is raised.
- **Any other nonzero syndrome:** the word is passed through untouched under an uncorrectable flag.

The minimum distance is 4, so every double error falls into this last class. The recovered message is bits 6:4 of the output word. Both paths run side by side and may accept input in the same cycle.

Top module: `cyc73_codec`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero, including both valid strobes and both flags.
- R2: `enc_valid_o` is high in exactly the cycles that follow a cycle with `enc_valid_i` high.
- R3: A codeword produced for message m carries m unchanged in bits 6:4, with m bit j in codeword bit 4+j.
- R4: Codeword bits 3:0 equal the remainder of m(x)·x^4 divided by g(x) = 1 + x + x^2 + x^4. In that remainder, bit k is the coefficient of x^k.
- R5: `dec_valid_o` is high in exactly the cycles that follow a cycle with `dec_valid_i` high.
- R6: `dec_syn_o` equals the remainder of r(x) divided by g(x), where r(x) is the accepted received word.
- R7: With a zero syndrome, the output word equals the received word and both flags are low. `dec_msg_o` always equals bits 6:4 of `dec_word_o`.
- R8: When the syndrome equals x^i mod g(x) for some i in 0..6, the output word is the received word with bit i inverted and `dec_corrected_o` is high. This corrects every single-bit error on every codeword.
- R9: A nonzero syndrome that matches no single-bit pattern raises `dec_uncorr_o`, keeps `dec_corrected_o` low and passes the received word unchanged. Every two-bit error on a codeword lands here.
- R10: A received word with bits 0, 1, 4, 5 and 6 set (1 1 0 0 1 1 1 listed from bit 0) yields syndrome 0001. It yields the corrected word 0 1 0 0 1 1 1 (from bit 0) and message 111.
- R11: In a cycle with a path's valid input low, that path's data outputs and flags keep their previous values.
- R12: `dec_corrected_o` and `dec_uncorr_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Message strobe for the encode path |
| enc_msg_i | input | 3 | Message, bit j is coefficient of x^(4+j) in the codeword |
| enc_valid_o | output | 1 | Codeword strobe, one cycle after the message |
| enc_code_o | output | 7 | Systematic codeword |
| dec_valid_i | input | 1 | Received-word strobe for the decode path |
| dec_word_i | input | 7 | Received word |
| dec_valid_o | output | 1 | Result strobe, one cycle after the word |
| dec_word_o | output | 7 | Corrected (or passed-through) word |
| dec_msg_o | output | 3 | Recovered message, bits 6:4 of the output word |
| dec_syn_o | output | 4 | Syndrome of the received word |
| dec_corrected_o | output | 1 | A single-bit error was located and inverted |
| dec_uncorr_o | output | 1 | Nonzero syndrome with no single-bit match |

## Verification
The bench walks all eight codewords through the decoder in three forms: clean, with each of the seven single-bit flips, and with each of the 21 two-bit flips.

- A division that shifted in the wrong bit order or used a wrong tap would show a nonzero syndrome on clean words.
- A locator with a swapped or missing pattern would invert the wrong bit or report a single error as uncorrectable.
- A locator that matched too freely would "correct" double errors into a third wrong word instead of flagging them.

The fixed example word checks the exact syndrome, the corrected word and the message. A long random stream with idle gaps catches outputs that fail to hold between strobes, and strobes that are one cycle late or stuck.

// File: rtl/cyc73_pkg.sv
package cyc73_pkg;

    // Default code geometry: 7-bit words carrying 3 message bits.
    localparam int CW_LEN  = 7;
    localparam int MSG_LEN = 3;

    // Generator 1 + x + x^2 + x^4, bit k = coefficient of x^k.
    localparam logic [CW_LEN-MSG_LEN:0] GEN_POLY = 5'b10111;

    // Outcome of the syndrome inspection.
    typedef enum logic [1:0] {
        DEC_CLEAN = 2'd0,
        DEC_FIXED = 2'd1,
        DEC_FAIL  = 2'd2
    } dec_class_e;

endpackage

// File: rtl/cyc73_polydiv.sv
// Remainder of an N-bit polynomial divided by a monic generator of degree P.
// Unrolled shift-and-subtract chain, highest coefficient first.
module cyc73_polydiv #(
    parameter int         N   = 7,
    parameter int         P   = 4,
    parameter logic [P:0] GEN = 5'b10111
) (
    input  logic [N-1:0] dividend_i,
    output logic [P-1:0] rem_o
);

    localparam logic [P-1:0] TAPS = GEN[P-1:0];

    logic [N:0][P-1:0] chain;

    assign chain[0] = '0;

    for (genvar s = 0; s < N; s++) begin : g_stage
        localparam int BIT = N - 1 - s;
        assign chain[s+1] = {chain[s][P-2:0], dividend_i[BIT]}
                          ^ (chain[s][P-1] ? TAPS : '0);
    end

    assign rem_o = chain[N];

endmodule

// File: rtl/cyc73_locator.sv
// Maps a syndrome onto a single-bit error position, if one exists.
module cyc73_locator #(
    parameter int         N   = 7,
    parameter int         P   = 4,
    parameter logic [P:0] GEN = 5'b10111
) (
    input  logic [P-1:0] syn_i,
    output logic [N-1:0] flip_o,
    output logic         hit_o,
    output logic         miss_o
);

    localparam logic [P-1:0] TAPS = GEN[P-1:0];

    // x^e mod g(x), computed at elaboration.
    function automatic logic [P-1:0] xpow_mod(input int e);
        logic [P-1:0] r;
        r = P'(1);
        for (int j = 0; j < e; j++) begin
            r = {r[P-2:0], 1'b0} ^ (r[P-1] ? TAPS : '0);
        end
        return r;
    endfunction

    for (genvar i = 0; i < N; i++) begin : g_pat
        localparam logic [P-1:0] PAT = xpow_mod(i);
        assign flip_o[i] = (syn_i == PAT);
    end

    assign hit_o  = |flip_o;
    assign miss_o = (syn_i != '0) && !hit_o;

endmodule

// File: rtl/cyc73_encoder.sv
module cyc73_encoder #(
    parameter int           N   = 7,
    parameter int           K   = 3,
    parameter logic [N-K:0] GEN = 5'b10111
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [K-1:0] msg_i,
    output logic         valid_o,
    output logic [N-1:0] code_o
);

    localparam int P = N - K;

    typedef struct packed {
        logic         valid;
        logic [N-1:0] code;
    } enc_state_t;

    enc_state_t   st_d, st_q;
    logic [N-1:0] shifted;
    logic [P-1:0] parity;

    assign shifted = {msg_i, {P{1'b0}}};

    cyc73_polydiv #(.N(N), .P(P), .GEN(GEN)) u_div (
        .dividend_i (shifted),
        .rem_o      (parity)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.code = {msg_i, parity};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign code_o  = st_q.code;

endmodule

// File: rtl/cyc73_decoder.sv
module cyc73_decoder #(
    parameter int           N   = 7,
    parameter int           K   = 3,
    parameter logic [N-K:0] GEN = 5'b10111
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [N-1:0] word_i,
    output logic         valid_o,
    output logic [N-1:0] word_o,
    output logic [K-1:0] msg_o,
    output logic [N-K-1:0] syn_o,
    output logic         corrected_o,
    output logic         uncorr_o
);

    import cyc73_pkg::*;

    localparam int P = N - K;

    typedef struct packed {
        logic         valid;
        logic [N-1:0] word;
        logic [K-1:0] msg;
        logic [P-1:0] syn;
        logic         fixed;
        logic         fail;
    } dec_state_t;

    dec_state_t   st_d, st_q;
    logic [P-1:0] syn;
    logic [N-1:0] flip;
    logic         hit;
    logic         miss;
    logic [N-1:0] repaired;
    dec_class_e   cls;

    cyc73_polydiv #(.N(N), .P(P), .GEN(GEN)) u_div (
        .dividend_i (word_i),
        .rem_o      (syn)
    );

    cyc73_locator #(.N(N), .P(P), .GEN(GEN)) u_loc (
        .syn_i  (syn),
        .flip_o (flip),
        .hit_o  (hit),
        .miss_o (miss)
    );

    always_comb begin
        cls = DEC_CLEAN;
        if (miss) begin
            cls = DEC_FAIL;
        end else if (hit) begin
            cls = DEC_FIXED;
        end
        repaired = word_i ^ ((cls == DEC_FIXED) ? flip : '0);

        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.word  = repaired;
            st_d.msg   = repaired[N-1:P];
            st_d.syn   = syn;
            st_d.fixed = (cls == DEC_FIXED);
            st_d.fail  = (cls == DEC_FAIL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o     = st_q.valid;
    assign word_o      = st_q.word;
    assign msg_o       = st_q.msg;
    assign syn_o       = st_q.syn;
    assign corrected_o = st_q.fixed;
    assign uncorr_o    = st_q.fail;

endmodule

// File: rtl/cyc73_codec.sv
module cyc73_codec #(
    parameter int           N   = cyc73_pkg::CW_LEN,
    parameter int           K   = cyc73_pkg::MSG_LEN,
    parameter logic [N-K:0] GEN = cyc73_pkg::GEN_POLY
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enc_valid_i,
    input  logic [K-1:0]   enc_msg_i,
    output logic           enc_valid_o,
    output logic [N-1:0]   enc_code_o,
    input  logic           dec_valid_i,
    input  logic [N-1:0]   dec_word_i,
    output logic           dec_valid_o,
    output logic [N-1:0]   dec_word_o,
    output logic [K-1:0]   dec_msg_o,
    output logic [N-K-1:0] dec_syn_o,
    output logic           dec_corrected_o,
    output logic           dec_uncorr_o
);

    cyc73_encoder #(.N(N), .K(K), .GEN(GEN)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (enc_valid_i),
        .msg_i   (enc_msg_i),
        .valid_o (enc_valid_o),
        .code_o  (enc_code_o)
    );

    cyc73_decoder #(.N(N), .K(K), .GEN(GEN)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (dec_valid_i),
        .word_i      (dec_word_i),
        .valid_o     (dec_valid_o),
        .word_o      (dec_word_o),
        .msg_o       (dec_msg_o),
        .syn_o       (dec_syn_o),
        .corrected_o (dec_corrected_o),
        .uncorr_o    (dec_uncorr_o)
    );

endmodule

// File: rtl/cyc73_codec_chk.sv
module cyc73_codec_chk #(
    parameter int N = 7,
    parameter int K = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enc_valid_i,
    input logic [K-1:0]   enc_msg_i,
    input logic           enc_valid_o,
    input logic [N-1:0]   enc_code_o,
    input logic           dec_valid_i,
    input logic [N-1:0]   dec_word_i,
    input logic           dec_valid_o,
    input logic [N-1:0]   dec_word_o,
    input logic [K-1:0]   dec_msg_o,
    input logic [N-K-1:0] dec_syn_o,
    input logic           dec_corrected_o,
    input logic           dec_uncorr_o
);

    localparam int P = N - K;

    assert_enc_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);

    assert_enc_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> !enc_valid_o);

    assert_msg_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> (enc_code_o[N-1:P] == $past(enc_msg_i)));

    assert_enc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> $stable(enc_code_o));

    assert_dec_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);

    assert_dec_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> ($stable(dec_word_o) && $stable(dec_syn_o)
                          && $stable(dec_corrected_o) && $stable(dec_uncorr_o)));

    assert_clean_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_syn_o == '0) |-> (!dec_corrected_o && !dec_uncorr_o));

    assert_msg_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> (dec_msg_o == dec_word_o[N-1:P]));

    assert_one_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> (dec_corrected_o ==
                         ($countones(dec_word_o ^ $past(dec_word_i)) == 1)));

    assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> (!dec_uncorr_o || (dec_word_o == $past(dec_word_i))));

    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_corrected_o && dec_uncorr_o));

endmodule

bind cyc73_codec cyc73_codec_chk #(.N(N), .K(K)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enc_valid_i     (enc_valid_i),
    .enc_msg_i       (enc_msg_i),
    .enc_valid_o     (enc_valid_o),
    .enc_code_o      (enc_code_o),
    .dec_valid_i     (dec_valid_i),
    .dec_word_i      (dec_word_i),
    .dec_valid_o     (dec_valid_o),
    .dec_word_o      (dec_word_o),
    .dec_msg_o       (dec_msg_o),
    .dec_syn_o       (dec_syn_o),
    .dec_corrected_o (dec_corrected_o),
    .dec_uncorr_o    (dec_uncorr_o)
);

// File: tb/sim_cyc73_codec.sv
module sim_cyc73_codec;

    localparam int CLK_PERIOD = 10;
    localparam int GPOLY      = 23; // 1 + x + x^2 + x^4

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_valid_i = 1'b0;
    logic [2:0] enc_msg_i = '0;
    logic       enc_valid_o;
    logic [6:0] enc_code_o;
    logic       dec_valid_i = 1'b0;
    logic [6:0] dec_word_i = '0;
    logic       dec_valid_o;
    logic [6:0] dec_word_o;
    logic [2:0] dec_msg_o;
    logic [3:0] dec_syn_o;
    logic       dec_corrected_o;
    logic       dec_uncorr_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  cmp_on   = 1'b0;
    bit  finished = 1'b0;

    cyc73_codec u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .enc_valid_i     (enc_valid_i),
        .enc_msg_i       (enc_msg_i),
        .enc_valid_o     (enc_valid_o),
        .enc_code_o      (enc_code_o),
        .dec_valid_i     (dec_valid_i),
        .dec_word_i      (dec_word_i),
        .dec_valid_o     (dec_valid_o),
        .dec_word_o      (dec_word_o),
        .dec_msg_o       (dec_msg_o),
        .dec_syn_o       (dec_syn_o),
        .dec_corrected_o (dec_corrected_o),
        .dec_uncorr_o    (dec_uncorr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    function automatic int poly_mod(input int v);
        int r;
        r = v;
        for (int d = 6; d >= 4; d--) begin
            if (r[d]) r = r ^ (GPOLY << (d - 4));
        end
        return r & 15;
    endfunction

    function automatic int encode(input int m);
        return (m << 4) | poly_mod(m << 4);
    endfunction

    // kind: 0 clean, 1 fixed, 2 fail
    function automatic int classify(input int w, output int fixed_w);
        int s;
        s = poly_mod(w);
        fixed_w = w;
        if (s == 0) return 0;
        for (int i = 0; i < 7; i++) begin
            if (poly_mod(1 << i) == s) begin
                fixed_w = w ^ (1 << i);
                return 1;
            end
        end
        return 2;
    endfunction

    int m_ev = 0, m_code = 0, m_dv = 0, m_word = 0, m_syn = 0, m_kind = 0;
    int m_fix = 0, m_fail = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ev = 0; m_code = 0; m_dv = 0; m_word = 0; m_syn = 0;
            m_fix = 0; m_fail = 0; m_kind = 0;
        end else begin
            int fw;
            m_ev = int'(enc_valid_i);
            if (enc_valid_i) m_code = encode(int'(enc_msg_i));
            m_dv = int'(dec_valid_i);
            if (dec_valid_i) begin
                m_kind = classify(int'(dec_word_i), fw);
                m_word = fw;
                m_syn  = poly_mod(int'(dec_word_i));
                m_fix  = (m_kind == 1) ? 1 : 0;
                m_fail = (m_kind == 2) ? 1 : 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            string wt;
            wt = (m_kind == 0) ? "R7 word" : (m_kind == 1) ? "R8 word" : "R9 word";
            chk("R2 enc_valid", 32'(enc_valid_o), 32'(m_ev));
            chk("R4 codeword", 32'(enc_code_o), 32'(m_code));
            chk("R5 dec_valid", 32'(dec_valid_o), 32'(m_dv));
            chk("R6 syndrome", 32'(dec_syn_o), 32'(m_syn));
            chk(wt, 32'(dec_word_o), 32'(m_word));
            chk("R7 message", 32'(dec_msg_o), 32'(m_word >> 4));
            chk("R8 corrected flag", 32'(dec_corrected_o), 32'(m_fix));
            chk("R9 uncorrectable flag", 32'(dec_uncorr_o), 32'(m_fail));
            chk("R12 exclusive flags", 32'(dec_corrected_o & dec_uncorr_o), 32'd0);
        end
    end

    task automatic enc_one(input int m);
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_msg_i   = 3'(m);
        @(negedge clk);
        enc_valid_i = 1'b0;
    endtask

    task automatic dec_one(input int w);
        @(negedge clk);
        dec_valid_i = 1'b1;
        dec_word_i  = 7'(w);
        @(negedge clk);
        dec_valid_i = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 enc_valid", 32'(enc_valid_o), 32'd0);
        chk("R1 codeword", 32'(enc_code_o), 32'd0);
        chk("R1 dec_valid", 32'(dec_valid_o), 32'd0);
        chk("R1 dec outputs", {dec_word_o, dec_msg_o, dec_syn_o}, 32'd0);
        chk("R1 flags", 32'({dec_corrected_o, dec_uncorr_o}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'({enc_valid_o, dec_valid_o}), 32'd0);
        cmp_on = 1'b1;

        // R3/R4: every message, checked field by field
        for (int m = 0; m < 8; m++) begin
            enc_one(m);
            chk("R3 message field", 32'(enc_code_o[6:4]), 32'(m));
            chk("R4 parity field", 32'(enc_code_o[3:0]), 32'(poly_mod(m << 4)));
        end

        // R10: the fixed example word
        dec_one(7'b1110011);
        chk("R10 syndrome", 32'(dec_syn_o), 32'h1);
        chk("R10 corrected word", 32'(dec_word_o), 32'b1110010);
        chk("R10 message", 32'(dec_msg_o), 32'b111);
        chk("R10 corrected flag", 32'(dec_corrected_o), 32'd1);

        // R7/R8/R9: clean, single and double errors on every codeword
        for (int m = 0; m < 8; m++) begin
            int cw;
            cw = encode(m);
            dec_one(cw);
            chk("R7 clean syndrome", 32'(dec_syn_o), 32'd0);
            chk("R7 clean word", 32'(dec_word_o), 32'(cw));
            for (int i = 0; i < 7; i++) begin
                dec_one(cw ^ (1 << i));
                chk("R8 single repaired", 32'(dec_word_o), 32'(cw));
                chk("R8 single message", 32'(dec_msg_o), 32'(m));
                chk("R8 single flag", 32'(dec_corrected_o), 32'd1);
            end
            for (int i = 0; i < 7; i++) begin
                for (int j = i + 1; j < 7; j++) begin
                    dec_one(cw ^ (1 << i) ^ (1 << j));
                    chk("R9 double flag", 32'({dec_corrected_o, dec_uncorr_o}), 32'b01);
                    chk("R9 double unchanged", 32'(dec_word_o), 32'(cw ^ (1 << i) ^ (1 << j)));
                end
            end
        end

        // R11 and streaming: random traffic on both paths with gaps
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            enc_valid_i = 1'($urandom_range(0, 1));
            enc_msg_i   = 3'($urandom);
            dec_valid_i = 1'($urandom_range(0, 1));
            dec_word_i  = 7'($urandom);
        end
        @(negedge clk);
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        begin
            logic [6:0] held_code;
            logic [6:0] held_word;
            @(negedge clk);
            held_code = enc_code_o;
            held_word = dec_word_o;
            enc_msg_i  = 3'd5;
            dec_word_i = 7'h55;
            repeat (3) @(negedge clk);
            chk("R11 codeword held", 32'(enc_code_o), 32'(held_code));
            chk("R11 word held", 32'(dec_word_o), 32'(held_word));
        end

        cmp_on = 1'b0;
        summary();
    end

endmodule